// File: doc/BRIEF.md
# Guarded Return-Address Stack

This block holds subroutine return addresses in dedicated storage, kept apart from the general-purpose data stack. A buffer overrun inside a stack frame therefore cannot reach a saved return address. A call instruction stores its return address implicitly. A return instruction takes the newest entry back in the same cycle and hands it on as the next program counter.

Apart from call and return, only two dedicated instructions may change the storage: an explicit push and an explicit pop. An explicit push is accepted only when its operand carries the address type tag. Any other write aimed at the storage, such as an ordinary store, is refused and reported.

Every refused or impossible request raises a one-cycle fault pulse with a cause code one cycle later. Refused and impossible requests include:
- a tag mismatch,
- a foreign write,
- an overflow,
- an underflow,
- a clash between requests in the same cycle.

Top module: `retstack_guard`

## Requirements
- R1: After reset the stack is empty, `popValid` and `fault` are low, and `faultCause` is 0.
- R2: `callReq` pushes `callAddr`. `retReq` returns the newest entry on `popAddr` in the same cycle, with `popValid` high for that cycle only. Entries come back in last-in, first-out order.
- R3: `pushReq` with `pushTag` equal to 2 (the address tag) pushes `pushData`. `popReq` returns the newest entry in the same cycle, exactly as a return does.
- R4: `pushReq` with any tag other than 2 pushes nothing. In the next cycle it raises `fault` with cause 2. The tag codes are: 0 null, 1 instruction, 2 address, 3 value, 4 reference.
- R5: `rogueWrite` (any write to the stack by a non-dedicated instruction) changes nothing and raises `fault` with cause 1 in the next cycle.
- R6: A push while DEPTH entries are held is dropped and raises `fault` with cause 3 in the next cycle.
- R7: A pop while the stack is empty returns nothing (`popValid` low) and raises `fault` with cause 4 in the next cycle.
- R8: If a push and a pop request arrive in the same cycle, the push is performed, the pop is dropped, and cause 5 is raised. The same cause is raised in two more cases:
  - `callReq` with `pushReq`: the call is pushed and the explicit push is dropped.
  - `retReq` with `popReq`: a single pop is performed.
- R9: `fault` is a registered pulse that lasts one cycle for each faulty request cycle. When several causes coincide, the reported cause follows the priority 1 > 5 > 2 > 3 > 4. `faultCause` is 0 whenever `fault` is low.
- R10: `popAddr` is zero in every cycle where `popValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Call instruction: implicit push |
| callAddr | input | AW | Return address stored by a call |
| retReq | input | 1 | Return instruction: implicit pop |
| pushReq | input | 1 | Dedicated explicit push |
| pushData | input | AW | Operand of the explicit push |
| pushTag | input | 3 | Type tag of the explicit push operand |
| popReq | input | 1 | Dedicated explicit pop |
| rogueWrite | input | 1 | Write attempt by any other instruction |
| popAddr | output | AW | Popped address, zero when not valid |
| popValid | output | 1 | Pop performed this cycle |
| fault | output | 1 | Protection fault pulse, one cycle late |
| faultCause | output | 3 | Fault cause code, 0 when no fault |

## Verification
The bench builds the block with DEPTH = 4 and AW = 16. With only four entries the full boundary is reached within a handful of calls. Overflow, draining back to empty, and underflow can therefore all be driven many times within a few hundred random cycles. The narrow address width keeps the random return addresses distinct enough to expose an ordering error without lengthening the run.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [2:0] {
    TAG_NULL  = 3'd0,
    TAG_INSTR = 3'd1,
    TAG_ADDR  = 3'd2,
    TAG_VALUE = 3'd3,
    TAG_REF   = 3'd4
  } tag_e;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_ROGUE   = 3'd1,
    FC_TAG     = 3'd2,
    FC_OVER    = 3'd3,
    FC_UNDER   = 3'd4,
    FC_COLLIDE = 3'd5
  } fault_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic fromCall;
  } strobe_t;

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          callReq,
  input  logic          retReq,
  input  logic          pushReq,
  input  logic [2:0]    pushTag,
  input  logic          popReq,
  input  logic          rogueWrite,
  input  logic          full,
  input  logic          empty,
  output strobe_t       stb,
  output logic          fault,
  output logic [2:0]    faultCause
);

  logic pushWant, popWant, collide, tagBad, pushOk, overErr, popTry, underErr;
  fault_e causeNext;

  always_comb begin
    pushWant = callReq | pushReq;
    popWant  = retReq | popReq;
    collide  = (callReq & pushReq) | (pushWant & popWant) | (retReq & popReq);
    tagBad   = pushReq & ~callReq & (pushTag != TAG_ADDR);
    pushOk   = callReq | (pushReq & ~tagBad);
    overErr  = pushOk & full;
    popTry   = popWant & ~pushWant;
    underErr = popTry & empty;

    stb.push     = pushOk & ~full;
    stb.fromCall = callReq;
    stb.pop      = popTry & ~empty;

    if (rogueWrite)    causeNext = FC_ROGUE;
    else if (collide)  causeNext = FC_COLLIDE;
    else if (tagBad)   causeNext = FC_TAG;
    else if (overErr)  causeNext = FC_OVER;
    else if (underErr) causeNext = FC_UNDER;
    else               causeNext = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fault      <= 1'b0;
      faultCause <= FC_NONE;
    end else begin
      fault      <= (causeNext != FC_NONE);
      faultCause <= causeNext;
    end
  end

  AST_ROGUE_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    rogueWrite |=> (fault && faultCause == FC_ROGUE)); // R5

  AST_BAD_TAG_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !callReq && pushTag != TAG_ADDR) |-> !stb.push); // R4

  AST_PUSH_BEATS_POP: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.push && stb.pop)); // R8

  AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> (faultCause == FC_NONE)); // R9

endmodule

// File: rtl/ras_store.sv
module ras_store
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] callAddr,
  input  logic [AW-1:0] pushData,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] topAddr
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] count;
  logic [IW-1:0] wrIdx, topIdx;
  logic [AW-1:0] wrData;

  always_comb begin
    full   = (count == CW'(DEPTH));
    empty  = (count == '0);
    wrIdx  = IW'(count);
    topIdx = IW'(count - CW'(1));
    wrData = stb.fromCall ? callAddr : pushData;
    topAddr = mem[topIdx];
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (stb.push) count <= count + CW'(1);
    else if (stb.pop)  count <= count - CW'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (count != CW'(DEPTH))); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> (count != '0)); // R7

  AST_PUSH_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |=> (topAddr == $past(stb.fromCall ? callAddr : pushData))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.push && !stb.pop) |=> $stable(count)); // R5

endmodule

// File: rtl/retstack_guard.sv
module retstack_guard
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          callReq,
  input  logic [AW-1:0] callAddr,
  input  logic          retReq,
  input  logic          pushReq,
  input  logic [AW-1:0] pushData,
  input  logic [2:0]    pushTag,
  input  logic          popReq,
  input  logic          rogueWrite,
  output logic [AW-1:0] popAddr,
  output logic          popValid,
  output logic          fault,
  output logic [2:0]    faultCause
);

  strobe_t       stb;
  logic          full, empty;
  logic [AW-1:0] topAddr;

  ras_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .pushReq(pushReq), .pushTag(pushTag), .popReq(popReq),
    .rogueWrite(rogueWrite), .full(full), .empty(empty), .stb(stb),
    .fault(fault), .faultCause(faultCause)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .callAddr(callAddr),
    .pushData(pushData), .full(full), .empty(empty), .topAddr(topAddr)
  );

  assign popValid = stb.pop;
  assign popAddr  = stb.pop ? topAddr : '0;

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !popValid |-> (popAddr == '0)); // R10

endmodule

// File: tb/sim_retstack_guard.sv
`timescale 1ns/1ps
module sim_retstack_guard;
  localparam int DEPTH = 4;
  localparam int AW    = 16;

  logic clk = 0, rstN = 0;
  logic callReq = 0, retReq = 0, pushReq = 0, popReq = 0, rogueWrite = 0;
  logic [AW-1:0] callAddr = '0, pushData = '0;
  logic [2:0] pushTag = '0;
  logic [AW-1:0] popAddr;
  logic popValid, fault;
  logic [2:0] faultCause;

  int checks = 0, fails = 0;
  logic [AW-1:0] q[$];
  logic expFault = 0;
  logic [2:0] expCause = 0;
  string prevLbl = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  retstack_guard #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .callReq(callReq), .callAddr(callAddr),
    .retReq(retReq), .pushReq(pushReq), .pushData(pushData),
    .pushTag(pushTag), .popReq(popReq), .rogueWrite(rogueWrite),
    .popAddr(popAddr), .popValid(popValid), .fault(fault),
    .faultCause(faultCause)
  );

  task automatic chk(input bit ok, input string lbl, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [AW-1:0] ca, input logic r,
                      input logic p, input logic [AW-1:0] pd, input logic [2:0] tg,
                      input logic o, input logic w, input string lbl);
    logic pushWant, popWant, collide, tagBad, pushOk, doPush, over, doPop, under;
    logic [AW-1:0] expAddr;
    @(negedge clk);
    chk(fault === expFault, prevLbl, "fault", fault, expFault);
    chk(faultCause === expCause, prevLbl, "faultCause", faultCause, expCause);
    callReq = c; callAddr = ca; retReq = r; pushReq = p; pushData = pd;
    pushTag = tg; popReq = o; rogueWrite = w;
    #1;
    pushWant = c | p;  popWant = r | o;
    collide  = (c & p) | (pushWant & popWant) | (r & o);
    tagBad   = p & ~c & (tg != 3'd2);
    pushOk   = c | (p & ~tagBad);
    doPush   = pushOk && (q.size() < DEPTH);
    over     = pushOk && (q.size() == DEPTH);
    doPop    = popWant && !pushWant && (q.size() > 0);
    under    = popWant && !pushWant && (q.size() == 0);
    expAddr  = doPop ? q[$] : '0;
    chk(popValid === doPop, lbl, "popValid", popValid, doPop);
    chk(popAddr === expAddr, doPop ? lbl : "R10", "popAddr", popAddr, expAddr);
    if (w)          expCause = 3'd1;
    else if (collide) expCause = 3'd5;
    else if (tagBad)  expCause = 3'd2;
    else if (over)    expCause = 3'd3;
    else if (under)   expCause = 3'd4;
    else              expCause = 3'd0;
    expFault = (expCause != 0);
    prevLbl = lbl;
    @(posedge clk);
    if (doPush) q.push_back(c ? ca : pd);
    else if (doPop) void'(q.pop_back());
  endtask

  task automatic idle(input string lbl);
    step(0, '0, 0, 0, '0, 3'd0, 0, 0, lbl);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    idle("R1");                                        // R1 reset state
    step(0, '0, 1, 0, '0, 0, 0, 0, "R7");              // R7 ret on empty
    step(1, 16'h1111, 0, 0, '0, 0, 0, 0, "R2");        // R2 calls
    step(1, 16'h2222, 0, 0, '0, 0, 0, 0, "R2");
    idle("R10");
    step(0, '0, 1, 0, '0, 0, 0, 0, "R2");              // R2 LIFO
    step(0, '0, 1, 0, '0, 0, 0, 0, "R2");
    step(0, '0, 0, 1, 16'hBEEF, 3'd2, 0, 0, "R3");     // R3 explicit push
    step(0, '0, 0, 0, '0, 0, 1, 0, "R3");              // R3 explicit pop
    step(0, '0, 0, 1, 16'hDEAD, 3'd3, 0, 0, "R4");     // R4 value tag refused
    step(0, '0, 0, 1, 16'hDEAD, 3'd1, 0, 0, "R4");     // R4 instruction tag refused
    step(0, '0, 0, 0, '0, 0, 1, 0, "R4");              // nothing was pushed
    step(0, '0, 0, 0, '0, 0, 0, 1, "R5");              // R5 foreign write
    step(0, '0, 0, 0, '0, 0, 1, 0, "R5");              // stack still empty
    for (int i = 0; i < DEPTH + 1; i++)
      step(1, AW'(16'h3000 + i), 0, 0, '0, 0, 0, 0, "R6"); // R6 overflow on last
    for (int i = 0; i < DEPTH + 1; i++)
      step(0, '0, 1, 0, '0, 0, 0, 0, "R7");            // drain then R7 underflow
    step(1, 16'h4444, 1, 0, '0, 0, 0, 0, "R8");        // R8 push beats pop
    step(1, 16'h5555, 0, 1, 16'h6666, 3'd2, 0, 0, "R8"); // R8 call beats push
    step(0, '0, 1, 0, '0, 0, 1, 0, "R8");              // R8 ret with pop
    step(0, '0, 0, 1, 16'h7777, 3'd0, 0, 1, "R9");     // R9 priority rogue over tag
    step(0, '0, 1, 0, '0, 0, 1, 1, "R9");              // R9 rogue over collide
    idle("R9");                                        // R9 pulse ends
    for (int i = 0; i < 600; i++) begin
      logic [2:0] tg;
      tg = ($urandom % 4 == 0) ? 3'($urandom % 5) : 3'd2;
      step(($urandom % 5) == 0, AW'($urandom), ($urandom % 6) == 0,
           ($urandom % 5) == 0, AW'($urandom), tg,
           ($urandom % 6) == 0, ($urandom % 25) == 0, "R9");
    end
    idle("R9");
    idle("R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule